// File: doc/BRIEF.md
# Memory Map Decoder with Runtime Boot-Window Remap

This block turns a 32-bit bus address, together with the access size and direction, into region selects for a small microcontroller. It recognises four regions: a 64 kB low window that holds the exception vectors, a 4 kB SRAM, a 64 kB flash and a 4 kB peripheral register region. The physical memory behind the low window is chosen at run time by a one-bit system map register that lives inside the peripheral region. Clearing the bit puts flash in the low window and setting it puts SRAM there. Software sets the bit, for example, to run vectors and code from SRAM while a flash page is being erased.

The decode is purely combinational in the same cycle as the address. The block outputs a one-hot target select, region-local offsets and little-endian byte lane enables for byte, halfword and word accesses. It raises an abort for any access that reaches no defined region, that is misaligned, or that uses the reserved size code. The system map register is the only state. It is written on the clock edge and read back through a dedicated read-data output.

Top module: `memmap_decoder`

## Requirements
- R1: With the map bit at 0, a valid access in 0x00000000–0x0000FFFF asserts `flash_sel`, and `flash_offset` equals address bits [15:0].
- R2: With the map bit at 1, a valid access in 0x00000000–0x0000FFFF asserts `sram_sel`, and `sram_offset` equals address bits [11:0]. Offsets above 4 kB alias onto the SRAM.
- R3: A valid access in 0x00040000–0x00040FFF asserts `sram_sel`, with `sram_offset` equal to address bits [11:0], whatever the map bit holds.
- R4: A valid access in 0x00080000–0x0008FFFF asserts `flash_sel`, with `flash_offset` equal to address bits [15:0], whatever the map bit holds.
- R5: A valid access in 0xFFFF0000–0xFFFF0FFF asserts `periph_sel`, with `periph_offset` equal to address bits [11:0].
- R6: A valid read or write to any other address asserts `abort` in the same cycle. Selects and lane enables are then all 0.
- R7: Size code 0 is byte, 1 is halfword, 2 is word and 3 is reserved. A halfword with address bit 0 set, a word with address bits [1:0] non-zero, or size 3 asserts `abort`, with selects and lanes all 0.
- R8: For an accepted access, `lane_en` is 4'b1111 for a word. For a halfword it is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a byte it is a one-hot with bit addr[1:0] set. With no valid access, or on abort, it is 0.
- R9: An accepted write to word address 0xFFFF0220 that enables lane 0 loads `map_wbit` into the map bit at the next rising clock edge. All other cycles leave the map bit unchanged.
- R10: A valid read accepted at word address 0xFFFF0220 returns the map bit on `map_rdata[0]` with zeros above it. `map_rdata` is 0 in every other cycle.
- R11: While `rst_n` is low, and after reset, the map bit is 0, so flash backs the low window.
- R12: At most one of `sram_sel`, `flash_sel` and `periph_sel` is high in any cycle, and none is high when `bus_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 32 | Byte address |
| map_wbit | input | 1 | Write data bit 0 |
| sram_sel | output | 1 | SRAM targeted |
| flash_sel | output | 1 | Flash targeted |
| periph_sel | output | 1 | Peripheral register region targeted |
| sram_offset | output | 12 | Byte offset inside SRAM |
| flash_offset | output | 16 | Byte offset inside flash |
| periph_offset | output | 12 | Byte offset inside the register region |
| lane_en | output | 4 | Byte lane enables, bit n = byte lane n |
| abort | output | 1 | Data abort for this access |
| map_rdata | output | 32 | Read data of the map register |
| map_sram | output | 1 | Current map bit (1 = SRAM in low window) |

## Verification
The bench uses the default parameters: a 64 kB low window, 4 kB SRAM and peripheral regions, and a 64 kB flash at the default bases. At these values every region edge lies a single byte away from an unmapped address, so the first and last byte of each region and the byte just outside it can be checked directly. Directed sequences toggle the map bit and probe the low window on both sides of the 4 kB SRAM alias. They also try map-register writes that must be ignored: a byte at 0x221, a misaligned halfword and a write while `bus_valid` is low. A seeded random phase mixes region-biased addresses with every size and direction, and the reference model is compared on every cycle.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LOW_AW     = 16,
  parameter int SRAM_AW    = 12,
  parameter int FLASH_AW   = 16,
  parameter int PERIPH_AW  = 12,
  parameter logic [AW-1:0] SRAM_BASE   = 32'h0004_0000,
  parameter logic [AW-1:0] FLASH_BASE  = 32'h0008_0000,
  parameter logic [AW-1:0] PERIPH_BASE = 32'hFFFF_0000,
  parameter logic [AW-1:0] MAP_OFFSET  = 32'h0000_0220
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 map_wbit,
  output logic                 sram_sel,
  output logic                 flash_sel,
  output logic                 periph_sel,
  output logic [SRAM_AW-1:0]   sram_offset,
  output logic [FLASH_AW-1:0]  flash_offset,
  output logic [PERIPH_AW-1:0] periph_offset,
  output logic [3:0]           lane_en,
  output logic                 abort,
  output logic [DW-1:0]        map_rdata,
  output logic                 map_sram
);

  localparam logic [AW-1:0] MAP_ADDR = PERIPH_BASE + MAP_OFFSET;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic in_low, in_sram, in_flash, in_periph, misalign, ok, map_hit, map_we;

  assign in_low    = (bus_addr >> LOW_AW) == '0;
  assign in_sram   = (bus_addr >> SRAM_AW)   == (SRAM_BASE >> SRAM_AW);
  assign in_flash  = (bus_addr >> FLASH_AW)  == (FLASH_BASE >> FLASH_AW);
  assign in_periph = (bus_addr >> PERIPH_AW) == (PERIPH_BASE >> PERIPH_AW);

  assign misalign = (bus_size == SZ_HALF && bus_addr[0])
                  || (bus_size == SZ_WORD && bus_addr[1:0] != 2'b00)
                  || (bus_size == 2'b11);

  assign abort = bus_valid && (misalign || !(in_low || in_sram || in_flash || in_periph));
  assign ok    = bus_valid && !abort;

  assign sram_sel   = ok && (in_sram  || (in_low && map_sram));
  assign flash_sel  = ok && (in_flash || (in_low && !map_sram));
  assign periph_sel = ok && in_periph;

  assign sram_offset   = bus_addr[SRAM_AW-1:0];
  assign flash_offset  = bus_addr[FLASH_AW-1:0];
  assign periph_offset = bus_addr[PERIPH_AW-1:0];

  always_comb begin
    lane_en = 4'b0000;
    if (ok) begin
      case (bus_size)
        SZ_BYTE: lane_en = 4'b0001 << bus_addr[1:0];
        SZ_HALF: lane_en = bus_addr[1] ? 4'b1100 : 4'b0011;
        default: lane_en = 4'b1111;
      endcase
    end
  end

  assign map_hit   = periph_sel && (bus_addr[AW-1:2] == MAP_ADDR[AW-1:2]);
  assign map_we    = map_hit && bus_write && lane_en[0];
  assign map_rdata = (map_hit && !bus_write) ? {{(DW-1){1'b0}}, map_sram} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_sram <= 1'b0;
    else if (map_we) map_sram <= map_wbit;
  end

  p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_sel, flash_sel, periph_sel}) && (bus_valid || !(sram_sel || flash_sel || periph_sel)));

  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!sram_sel && !flash_sel && !periph_sel && lane_en == 4'b0000));

  p_byte_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !abort && bus_size == SZ_BYTE) |-> $countones(lane_en) == 1);

  p_word_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !abort && bus_size == SZ_WORD) |-> lane_en == 4'b1111);

  p_map_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_sel && bus_write && bus_addr[AW-1:2] == MAP_ADDR[AW-1:2] && lane_en[0])
      |=> map_sram == $past(map_wbit));

  p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(periph_sel && bus_write && bus_addr[AW-1:2] == MAP_ADDR[AW-1:2] && lane_en[0])
      |=> $stable(map_sram));

  p_low_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !abort && bus_addr < 32'h0001_0000) |-> (flash_sel == !map_sram && sram_sel == map_sram));

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid || bus_write) |-> map_rdata == '0);

endmodule

// File: tb/tb_memmap_decoder.sv
module tb_memmap_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, map_wbit = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [31:0] bus_addr = 32'd0;
  logic sram_sel, flash_sel, periph_sel, abort, map_sram;
  logic [11:0] sram_offset, periph_offset;
  logic [15:0] flash_offset;
  logic [3:0] lane_en;
  logic [31:0] map_rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  bit model_map = 0;

  always #10 clk = ~clk;

  memmap_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .map_wbit(map_wbit),
    .sram_sel(sram_sel), .flash_sel(flash_sel), .periph_sel(periph_sel),
    .sram_offset(sram_offset), .flash_offset(flash_offset), .periph_offset(periph_offset),
    .lane_en(lane_en), .abort(abort), .map_rdata(map_rdata), .map_sram(map_sram)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model; the map-bit update is applied at the following posedge
  bit pend_we; bit pend_val;

  task automatic access(input bit v, input bit w, input int sz, input longint a, input bit wb);
    bit e_abort, e_s, e_f, e_p, mis, reg_hit;
    int region; logic [3:0] e_lane; longint e_rd; string tag;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_size = sz[1:0]; bus_addr = a[31:0]; map_wbit = wb;
    #1;
    region = 0;
    if (a <= 64'h0000_FFFF) region = 1;
    else if (a >= 64'h0004_0000 && a <= 64'h0004_0FFF) region = 2;
    else if (a >= 64'h0008_0000 && a <= 64'h0008_FFFF) region = 3;
    else if (a >= 64'hFFFF_0000 && a <= 64'hFFFF_0FFF) region = 4;
    mis = (sz == 3) || (sz == 1 && a % 2 != 0) || (sz == 2 && a % 4 != 0);
    e_abort = v && (region == 0 || mis);
    e_s = v && !e_abort && (region == 2 || (region == 1 && model_map));
    e_f = v && !e_abort && (region == 3 || (region == 1 && !model_map));
    e_p = v && !e_abort && region == 4;
    e_lane = 4'b0000;
    if (v && !e_abort) begin
      if (sz == 2) e_lane = 4'b1111;
      else if (sz == 1) e_lane = (a % 4 >= 2) ? 4'b1100 : 4'b0011;
      else e_lane = 4'b0001 << (a % 4);
    end
    reg_hit = e_p && (a / 4 == 64'hFFFF_0220 / 4);
    e_rd = (reg_hit && !w) ? longint'(model_map) : 0;
    case (region)
      1: tag = model_map ? "R2" : "R1";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = "R5";
      default: tag = "R6";
    endcase
    if (mis && v) tag = "R7";
    chk(tag, "abort", abort, e_abort);
    chk(tag, "sram_sel", sram_sel, e_s);
    chk(tag, "flash_sel", flash_sel, e_f);
    chk(tag, "periph_sel", periph_sel, e_p);
    if (e_s) chk(tag, "sram_offset", sram_offset, a % 4096);
    if (e_f) chk(tag, "flash_offset", flash_offset, a % 65536);
    if (e_p) chk(tag, "periph_offset", periph_offset, a % 4096);
    chk("R8", "lane_en", lane_en, e_lane);
    chk("R10", "map_rdata", map_rdata, e_rd);
    chk("R12", "one target", int'(sram_sel) + int'(flash_sel) + int'(periph_sel) <= 1, 1);
    pend_we = reg_hit && w && e_lane[0];
    pend_val = wb;
    @(posedge clk);
    if (pend_we) model_map = pend_val;
    #1;
    chk("R9", "map_sram", map_sram, model_map);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    bus_valid = 1; bus_size = 2; bus_addr = 32'hFFFF_0220;
    #1;
    chk("R11", "map_sram in reset", map_sram, 0);
    chk("R11", "map_rdata in reset", map_rdata, 0);
    bus_valid = 0;
    rst_n = 1;
    // R11: after reset flash backs address 0
    access(1, 0, 2, 64'h0, 0);
    access(1, 0, 2, 64'hFFFF_0220, 0);
    access(1, 0, 0, 64'hFFFF, 0);
    access(1, 0, 0, 64'h1_0000, 0);
    access(1, 0, 0, 64'h3_FFFF, 0);
    access(1, 1, 0, 64'h4_0000, 0);
    access(1, 0, 2, 64'h4_0FFC, 0);
    access(1, 0, 0, 64'h4_1000, 0);
    access(1, 0, 1, 64'h8_0000, 0);
    access(1, 0, 1, 64'h8_FFFE, 0);
    access(1, 0, 0, 64'h9_0000, 0);
    access(1, 0, 0, 64'hFFFF_0000, 0);
    access(1, 0, 0, 64'hFFFF_0FFF, 0);
    access(1, 0, 0, 64'hFFFF_1000, 0);
    access(1, 0, 0, 64'hFFFE_FFFF, 0);
    // R7 misalignment and reserved size
    access(1, 0, 1, 64'h8_0001, 0);
    access(1, 0, 2, 64'h8_0002, 0);
    access(1, 0, 3, 64'h8_0000, 0);
    // R8 lanes
    for (int i = 0; i < 4; i++) access(1, 0, 0, 64'h4_0010 + i, 0);
    access(1, 0, 1, 64'h4_0012, 0);
    // R9 ignored writes: no valid, byte lane 1, misaligned half, abort
    access(0, 1, 2, 64'hFFFF_0220, 1);
    access(1, 1, 0, 64'hFFFF_0221, 1);
    access(1, 1, 1, 64'hFFFF_0221, 1);
    access(1, 1, 2, 64'hFFFF_1220, 1);
    access(1, 0, 2, 64'hFFFF_0220, 0);
    // R9 real write sets the bit; R2 alias above 4 kB
    access(1, 1, 0, 64'hFFFF_0220, 1);
    access(1, 0, 2, 64'hFFFF_0220, 0);
    access(1, 0, 2, 64'h0000_0004, 0);
    access(1, 0, 2, 64'h0000_1004, 0);
    access(1, 0, 0, 64'h0000_FFFF, 0);
    access(1, 0, 2, 64'h0004_0004, 0);
    access(1, 0, 2, 64'h0008_0004, 0);
    access(1, 1, 2, 64'hFFFF_0220, 0);
    access(1, 0, 2, 64'h0000_0004, 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      longint a; int k;
      k = $urandom_range(0, 6);
      case (k)
        0: a = $urandom_range(0, 32'hFFFF);
        1: a = 64'h4_0000 + $urandom_range(0, 32'h1003) - 2;
        2: a = 64'h8_0000 + $urandom_range(0, 32'h1_0003) - 2;
        3: a = 64'hFFFF_0000 + $urandom_range(0, 32'h1003) - 2;
        4: a = 64'hFFFF_0220 + $urandom_range(0, 3);
        default: a = longint'($urandom);
      endcase
      if (a < 0) a = 0;
      access($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1,
             $urandom_range(0, 3), a, $urandom_range(0, 1) == 1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule